// File: doc/BRIEF.md
# Virtualization Intercept Decision Decoder

This block decides whether an event raised by a guest must leave the guest and return control to the host. Six intercept masks are held in registers and loaded through a simple write port. The masks cover control-register reads, control-register writes, debug-register reads, debug-register writes, exceptions, and a 64-bit general mask for all other events.

For each check request the block takes an event code and a flag that says whether the processor is running a guest. It sorts the code into one of several fixed code ranges, and each range has its own start offset into its own mask. The selected bit, qualified by the guest flag, gives a registered answer one cycle later. Model-specific-register access events get special handling. When such an event is intercepted, the block does not report an exit. It raises a referral output instead, so that a separate permission-bitmap lookup, outside this block, can make the final decision.

Top module: `ivd_intercept_decoder`

## Requirements
- R1: A synchronous active-low reset clears every mask. A write with `wr_en` high loads `wr_data` into the mask chosen by `wr_sel`: 0 CR-read, 1 CR-write, 2 DR-read, 3 DR-write, 4 exception, 5 general. Narrow masks take the low bits of `wr_data`.
- R2: Codes 0x000 to 0x008 select bit (code − 0x000) of the 16-bit CR-read mask.
- R3: Codes 0x010 to 0x018 select bit (code − 0x010) of the 16-bit CR-write mask.
- R4: Codes 0x020 to 0x027 select bit (code − 0x020) of the 16-bit DR-read mask.
- R5: Codes 0x030 to 0x037 select bit (code − 0x030) of the 16-bit DR-write mask.
- R6: Codes 0x040 to 0x05F select bit (code − 0x040) of the 32-bit exception mask.
- R7: Codes from 0x060 upward select bit (code − 0x060) of the 64-bit general mask. If that index is 64 or more, the answer is a miss. Codes below 0x060 that fall outside the ranged groups are also a miss.
- R8: When `chk_guest` is low, neither `rsp_hit` nor `rsp_delegate` is ever raised, whatever the masks hold.
- R9: For code 0x07C (general bit 28), a set bit gives `rsp_delegate`=1 and `rsp_hit`=0, and a clear bit gives both 0. No other code raises `rsp_delegate`.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `chk_valid` high. `rsp_hit` and `rsp_delegate` are low whenever `rsp_valid` is low, including after reset.
- R11: Writes with `wr_sel` 6 or 7 change no mask.
- R12: A check issued in the same cycle as a mask write is answered with the mask value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Mask write strobe |
| wr_sel | input | 3 | Mask select for the write |
| wr_data | input | 64 | Mask write value |
| chk_valid | input | 1 | Check request |
| chk_code | input | 12 | Event code to classify |
| chk_guest | input | 1 | High while running a guest |
| rsp_valid | output | 1 | Answer valid, one cycle after the request |
| rsp_hit | output | 1 | Event must exit to host |
| rsp_delegate | output | 1 | Refer to permission-bitmap check |

## Verification
A wrong mask register or a mis-decoded range shows up as a wrong `rsp_hit` on the first check that touches that bit. The bench therefore sweeps every code of each range, plus the gap codes on either side, against masks with scattered bits. A corrupted response register or a wrong guest qualification appears on the very next `rsp_valid` cycle, so every answer is compared in the cycle it appears. Wrong write decoding stays hidden until a later check reads the affected mask. For that reason, each ignored or overlapping write is followed at once by checks on all six masks.

// File: rtl/ivd_pkg.sv
// Package: shared constants, group encoding and range table helpers for the
// intercept decision decoder. Assumes 12-bit event codes.
package ivd_pkg;

    localparam int CODE_W     = 12;
    localparam int NUM_RANGED = 5;

    // Group encoding; also used as the write-port mask select value.
    typedef enum logic [2:0] {
        GRP_CRR  = 3'd0,
        GRP_CRW  = 3'd1,
        GRP_DRR  = 3'd2,
        GRP_DRW  = 3'd3,
        GRP_EXC  = 3'd4,
        GRP_GEN  = 3'd5,
        GRP_NONE = 3'd7
    } ivd_grp_e;

    localparam logic [CODE_W-1:0] GEN_BASE = 12'h060;
    localparam logic [CODE_W-1:0] MSR_CODE = 12'h07C;
    localparam logic [CODE_W-1:0] IO_CODE  = 12'h07B;

    // First code of each ranged group
    function automatic logic [CODE_W-1:0] grp_base(input int g);
        case (g)
            0:       return 12'h000;
            1:       return 12'h010;
            2:       return 12'h020;
            3:       return 12'h030;
            4:       return 12'h040;
            default: return 12'hFFF;
        endcase
    endfunction

    // Number of codes in each ranged group
    function automatic logic [CODE_W-1:0] grp_span(input int g);
        case (g)
            0, 1:    return 12'd9;
            2, 3:    return 12'd8;
            4:       return 12'd32;
            default: return 12'd0;
        endcase
    endfunction

endpackage

// File: rtl/ivd_mask_reg.sv
// Module: one intercept mask register. Loads on a matching write select,
// clears on synchronous active-low reset. Assumes W <= source width.
module ivd_mask_reg #(
    parameter int               W      = 16,
    parameter int               SEL_W  = 3,
    parameter logic [SEL_W-1:0] MY_SEL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_val,
    output logic [W-1:0]     mask_q
);

    // Hold the mask; replace it when this register is addressed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && (wr_sel == MY_SEL)) begin
            mask_q <= wr_val;
        end
    end

endmodule

// File: rtl/ivd_classifier.sv
// Module: sorts an event code into a mask group and a bit index.
// Ranged groups are checked first; remaining codes at or above the general
// base map into the general mask, otherwise the code belongs to no group.
module ivd_classifier
    import ivd_pkg::*;
#(
    parameter int GEN_W = 64,
    localparam int IDX_W = $clog2(GEN_W)
) (
    input  logic [CODE_W-1:0] code,
    output ivd_grp_e          grp,
    output logic [IDX_W-1:0]  idx,
    output logic              is_msr
);

    localparam logic [CODE_W-1:0] GEN_LIM = CODE_W'(GEN_W);

    logic [NUM_RANGED-1:0] in_rng;
    logic [CODE_W-1:0]     gen_off;

    // One range comparator per ranged group
    generate
        for (genvar g = 0; g < NUM_RANGED; g++) begin : g_rng
            assign in_rng[g] = (code >= grp_base(g)) &&
                               (code < (grp_base(g) + grp_span(g)));
        end
    endgenerate

    assign gen_off = code - GEN_BASE;
    assign is_msr  = (code == MSR_CODE);

    // Pick the first matching range, else the general mask, else none
    always_comb begin
        logic found;
        found = 1'b0;
        grp   = GRP_NONE;
        idx   = '0;
        for (int g = 0; g < NUM_RANGED; g++) begin
            if (!found && in_rng[g]) begin
                found = 1'b1;
                grp   = ivd_grp_e'(3'(g));
                idx   = IDX_W'(code - grp_base(g));
            end
        end
        if (!found && (code >= GEN_BASE) && (gen_off < GEN_LIM)) begin
            grp = GRP_GEN;
            idx = IDX_W'(gen_off);
        end
    end

endmodule

// File: rtl/ivd_bit_pick.sv
// Module: selects one intercept bit from the mask named by the group.
// Narrow masks are zero-extended to the general width before indexing;
// the classifier guarantees indices stay inside each mask's range.
module ivd_bit_pick
    import ivd_pkg::*;
#(
    parameter int CR_W  = 16,
    parameter int DR_W  = 16,
    parameter int EXC_W = 32,
    parameter int GEN_W = 64,
    localparam int IDX_W = $clog2(GEN_W)
) (
    input  ivd_grp_e         grp,
    input  logic [IDX_W-1:0] idx,
    input  logic [CR_W-1:0]  crr,
    input  logic [CR_W-1:0]  crw,
    input  logic [DR_W-1:0]  drr,
    input  logic [DR_W-1:0]  drw,
    input  logic [EXC_W-1:0] exc,
    input  logic [GEN_W-1:0] gen,
    output logic             bit_o
);

    logic [GEN_W-1:0] sel_vec;

    // Route the chosen mask onto a common-width bus
    always_comb begin
        case (grp)
            GRP_CRR: sel_vec = {{(GEN_W-CR_W){1'b0}}, crr};
            GRP_CRW: sel_vec = {{(GEN_W-CR_W){1'b0}}, crw};
            GRP_DRR: sel_vec = {{(GEN_W-DR_W){1'b0}}, drr};
            GRP_DRW: sel_vec = {{(GEN_W-DR_W){1'b0}}, drw};
            GRP_EXC: sel_vec = {{(GEN_W-EXC_W){1'b0}}, exc};
            GRP_GEN: sel_vec = gen;
            default: sel_vec = '0;
        endcase
    end

    assign bit_o = (grp != GRP_NONE) && sel_vec[idx];

endmodule

// File: rtl/ivd_intercept_decoder.sv
// Module: top of the intercept decision decoder. Holds six masks, classifies
// each checked code, and registers a hit or referral answer one cycle later.
// Assumes at most one check per cycle; answers are not back-pressured.
module ivd_intercept_decoder
    import ivd_pkg::*;
#(
    parameter int CR_W   = 16,
    parameter int DR_W   = 16,
    parameter int EXC_W  = 32,
    parameter int GEN_W  = 64,
    localparam int SEL_W = 3,
    localparam int IDX_W = $clog2(GEN_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [GEN_W-1:0]  wr_data,
    input  logic              chk_valid,
    input  logic [CODE_W-1:0] chk_code,
    input  logic              chk_guest,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_delegate
);

    logic [CR_W-1:0]  crr_q, crw_q;
    logic [DR_W-1:0]  drr_q, drw_q;
    logic [EXC_W-1:0] exc_q;
    logic [GEN_W-1:0] gen_q;

    ivd_grp_e         grp;
    logic [IDX_W-1:0] idx;
    logic             is_msr;
    logic             mask_bit;
    logic             take;

    ivd_mask_reg #(.W(CR_W), .SEL_W(SEL_W), .MY_SEL(SEL_W'(GRP_CRR))) u_crr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_val(wr_data[CR_W-1:0]), .mask_q(crr_q));
    ivd_mask_reg #(.W(CR_W), .SEL_W(SEL_W), .MY_SEL(SEL_W'(GRP_CRW))) u_crw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_val(wr_data[CR_W-1:0]), .mask_q(crw_q));
    ivd_mask_reg #(.W(DR_W), .SEL_W(SEL_W), .MY_SEL(SEL_W'(GRP_DRR))) u_drr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_val(wr_data[DR_W-1:0]), .mask_q(drr_q));
    ivd_mask_reg #(.W(DR_W), .SEL_W(SEL_W), .MY_SEL(SEL_W'(GRP_DRW))) u_drw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_val(wr_data[DR_W-1:0]), .mask_q(drw_q));
    ivd_mask_reg #(.W(EXC_W), .SEL_W(SEL_W), .MY_SEL(SEL_W'(GRP_EXC))) u_exc (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_val(wr_data[EXC_W-1:0]), .mask_q(exc_q));
    ivd_mask_reg #(.W(GEN_W), .SEL_W(SEL_W), .MY_SEL(SEL_W'(GRP_GEN))) u_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_val(wr_data), .mask_q(gen_q));

    ivd_classifier #(.GEN_W(GEN_W)) u_cls (
        .code(chk_code), .grp(grp), .idx(idx), .is_msr(is_msr));

    ivd_bit_pick #(.CR_W(CR_W), .DR_W(DR_W), .EXC_W(EXC_W), .GEN_W(GEN_W)) u_pick (
        .grp(grp), .idx(idx), .crr(crr_q), .crw(crw_q), .drr(drr_q),
        .drw(drw_q), .exc(exc_q), .gen(gen_q), .bit_o(mask_bit));

    assign take = chk_valid && chk_guest && mask_bit;

    // Register the answer: exit for ordinary codes, referral for MSR access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_delegate <= 1'b0;
        end else begin
            rsp_valid    <= chk_valid;
            rsp_hit      <= take && !is_msr;
            rsp_delegate <= take && is_msr;
        end
    end

endmodule

// File: rtl/ivd_checker.sv
// Module: protocol and decision properties for the intercept decoder,
// attached to the top through bind. Observes ports only.
module ivd_checker
    import ivd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              chk_valid,
    input logic [CODE_W-1:0] chk_code,
    input logic              chk_guest,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_delegate
);

    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> rsp_valid);

    assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !rsp_valid);

    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_delegate));

    assert_host_no_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_guest) |=> (!rsp_hit && !rsp_delegate));

    assert_msr_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && (chk_code == MSR_CODE)) |=> !rsp_hit);

    assert_delegate_msr_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && (chk_code != MSR_CODE)) |=> !rsp_delegate);

    assert_gen_overflow_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && (chk_code >= 12'h0A0)) |=> !rsp_hit);

endmodule

bind ivd_intercept_decoder ivd_checker u_ivd_checker (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_code(chk_code),
    .chk_guest(chk_guest), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_delegate(rsp_delegate));

// File: tb/ivd_intercept_decoder_tb_top.sv
// Bench: scoreboard. Driver tasks push expected answers into a queue; a
// monitor pops and compares each answer when rsp_valid is seen.
module ivd_intercept_decoder_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        hit;
        logic        del;
        logic [11:0] code;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic        chk_valid = 1'b0;
    logic [11:0] chk_code = '0;
    logic        chk_guest = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_delegate;

    int total = 0;
    int bad = 0;
    exp_t sb_q[$];

    // Shadow masks kept from the requirements
    logic [15:0] m_crr = '0, m_crw = '0, m_drr = '0, m_drw = '0;
    logic [31:0] m_exc = '0;
    logic [63:0] m_gen = '0;

    ivd_intercept_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .chk_valid(chk_valid), .chk_code(chk_code),
        .chk_guest(chk_guest), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_delegate(rsp_delegate));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected decision from R2..R9
    function automatic void model(input logic [11:0] c, input logic g,
                                  output logic h, output logic d);
        logic b;
        if (c <= 12'h008)                         b = m_crr[c[3:0]];
        else if (c >= 12'h010 && c <= 12'h018)    b = m_crw[4'(c - 12'h010)];
        else if (c >= 12'h020 && c <= 12'h027)    b = m_drr[4'(c - 12'h020)];
        else if (c >= 12'h030 && c <= 12'h037)    b = m_drw[4'(c - 12'h030)];
        else if (c >= 12'h040 && c <= 12'h05F)    b = m_exc[5'(c - 12'h040)];
        else if (c >= 12'h060 && c < 12'h0A0)     b = m_gen[6'(c - 12'h060)];
        else                                      b = 1'b0;
        h = g && b && (c != 12'h07C);
        d = g && b && (c == 12'h07C);
    endfunction

    function automatic void shadow_write(input logic [2:0] s, input logic [63:0] v);
        case (s)
            3'd0: m_crr = v[15:0];
            3'd1: m_crw = v[15:0];
            3'd2: m_drr = v[15:0];
            3'd3: m_drw = v[15:0];
            3'd4: m_exc = v[31:0];
            3'd5: m_gen = v;
            default: ;
        endcase
    endfunction

    // Issue one check and queue its expected answer
    task automatic issue(input logic [11:0] c, input logic g, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = 1'b0;
        chk_valid = 1'b1; chk_code = c; chk_guest = g;
        model(c, g, e.hit, e.del);
        e.code = c; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic write_mask(input logic [2:0] s, input logic [63:0] v);
        @(negedge clk);
        chk_valid = 1'b0;
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        shadow_write(s, v);
    endtask

    // Write and check in one cycle; expectation uses the pre-write mask (R12)
    task automatic write_and_issue(input logic [2:0] s, input logic [63:0] v,
                                   input logic [11:0] c, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        chk_valid = 1'b1; chk_code = c; chk_guest = 1'b1;
        model(c, 1'b1, e.hit, e.del);
        e.code = c; e.tag = tag;
        sb_q.push_back(e);
        shadow_write(s, v);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0; chk_valid = 1'b0;
        end
    endtask

    task automatic sweep(input logic [11:0] lo, input logic [11:0] hi,
                         input logic g, input string tag);
        for (int c = int'(lo); c <= int'(hi); c++) issue(12'(c), g, tag);
    endtask

    // Touch every mask with a few codes after a write that must be ignored
    task automatic probe_all(input string tag);
        sweep(12'h000, 12'h008, 1'b1, tag);
        sweep(12'h010, 12'h018, 1'b1, tag);
        sweep(12'h020, 12'h027, 1'b1, tag);
        sweep(12'h030, 12'h037, 1'b1, tag);
        sweep(12'h040, 12'h05F, 1'b1, tag);
        sweep(12'h060, 12'h09F, 1'b1, tag);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Monitor: compare each answer, and check outputs quiet otherwise (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                total++;
                if (sb_q.size() == 0) begin
                    bad++;
                    $display("FAIL R10: rsp_valid=1 with no request, expected 0");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (rsp_hit !== e.hit || rsp_delegate !== e.del) begin
                        bad++;
                        $display("FAIL %s: code=%h hit=%b del=%b expected hit=%b del=%b",
                                 e.tag, e.code, rsp_hit, rsp_delegate, e.hit, e.del);
                    end
                end
            end else if (rsp_hit || rsp_delegate) begin
                total++;
                bad++;
                $display("FAIL R10: idle hit=%b del=%b expected 0 0", rsp_hit, rsp_delegate);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R10): outputs low
        @(negedge clk);
        total++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_delegate !== 1'b0) begin
            bad++;
            $display("FAIL R10: after reset valid/hit/del=%b%b%b expected 000",
                     rsp_valid, rsp_hit, rsp_delegate);
        end
        // R1: masks clear after reset -> every probe misses
        probe_all("R1");

        // R2 with upper data bits that must be dropped (R1)
        write_mask(3'd0, 64'hFFFF_0000_0000_0105);
        sweep(12'h000, 12'h00F, 1'b1, "R2");
        // R3
        write_mask(3'd1, 64'h0000_0000_0000_0112);
        sweep(12'h010, 12'h01F, 1'b1, "R3");
        // R4 / R5
        write_mask(3'd2, 64'h0000_0000_0000_0081);
        sweep(12'h020, 12'h02F, 1'b1, "R4");
        write_mask(3'd3, 64'hAAAA_0000_0000_0042);
        sweep(12'h030, 12'h03F, 1'b1, "R5");
        // R6
        write_mask(3'd4, 64'h1234_5678_8000_0C01);
        sweep(12'h040, 12'h05F, 1'b1, "R6");
        // R7: general mask, bit 28 (MSR) clear, bit 27 (I/O) set
        write_mask(3'd5, 64'h8000_0001_0800_0001);
        sweep(12'h060, 12'h0A1, 1'b1, "R7");
        issue(12'hFFF, 1'b1, "R7");
        issue(12'h009, 1'b1, "R7");
        issue(12'h03F, 1'b1, "R7");
        issue(12'h07B, 1'b1, "R7");
        // R9: MSR bit clear -> nothing; set -> referral only
        issue(12'h07C, 1'b1, "R9");
        write_mask(3'd5, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(12'h07C, 1'b1, "R9");
        issue(12'h07B, 1'b1, "R9");
        issue(12'h07C, 1'b0, "R9");
        issue(12'h0A0, 1'b1, "R7");
        // R8: host mode, everything masked in
        write_mask(3'd0, 64'hFFFF); write_mask(3'd4, 64'hFFFF_FFFF);
        sweep(12'h000, 12'h0A0, 1'b0, "R8");
        idle(2);
        // R11: selects 6 and 7 change nothing
        write_mask(3'd0, 64'h0); write_mask(3'd1, 64'h0); write_mask(3'd2, 64'h0);
        write_mask(3'd3, 64'h0); write_mask(3'd4, 64'h0); write_mask(3'd5, 64'h0);
        write_mask(3'd6, 64'hFFFF_FFFF_FFFF_FFFF);
        write_mask(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
        probe_all("R11");
        // R12: same-cycle write and check sees the old value
        write_mask(3'd0, 64'h0001);
        write_and_issue(3'd0, 64'h0000, 12'h000, "R12");
        issue(12'h000, 1'b1, "R12");
        write_and_issue(3'd5, 64'h0000_0000_1000_0000, 12'h07C, "R12");
        issue(12'h07C, 1'b1, "R12");
        // R10: back-to-back then a gap; queue must drain exactly
        issue(12'h001, 1'b1, "R10");
        idle(4);
        total++;
        if (sb_q.size() != 0) begin
            bad++;
            $display("FAIL R10: %0d answers missing, expected 0", sb_q.size());
        end
        summary();
        $finish;
    end

endmodule